// File: doc/BRIEF.md
# Paged Address Translation and Protection Unit

This unit turns the logical addresses a processor issues into physical addresses within a store of 128 physical pages, which covers 4 MB of DRAM. For each access it checks a per-page protection level against the processor mode. Every physical page owns one table slot. A slot holds a valid bit, the logical page number that maps onto that physical page, and a 2-bit protection level. Each lookup compares the logical page number of an access with all valid slots in parallel, in a single combinational path.

Software programs the unit only through stores whose address carries both the target and the value. The unit has no data input: the write data of such a store never reaches it. Stores in one address region load the control register, which holds the page size and an elevation bit for OS mode. Stores in a second region load a table slot. How the physical page number is packed into the store address depends on the page size currently in force, so the table must be reloaded after the page size changes.

Access outputs are combinational. An access that misses, or that the protection rules refuse, raises `abort_o` in the same cycle and produces no physical address.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every slot is invalid, the page size is 4 KB and OS elevation is off, so every access aborts.
- R2: A store with `wr_addr_i[25:23]` = 111 loads a table slot. A store with `wr_addr_i[25:17]` = 0x1B7 loads the control register. A store to any other address changes nothing.
- R3: In a control store, `wr_addr_i[3:2]` selects the page size: 00 = 4 KB, 01 = 8 KB, 10 = 16 KB, 11 = 32 KB. `wr_addr_i[12]` sets OS elevation.
- R4: In a slot store, `wr_addr_i[9:8]` is the protection level. `wr_addr_i[11:10]` gives the two most significant bits of the logical page number. The remaining low bits of the logical page number come from `wr_addr_i[22:12+s]`, where s is 0, 1, 2 or 3 for 4, 8, 16 or 32 KB pages.
- R5: The physical page number P[6:0] is unpacked from a slot store according to the page size:
  - 4 KB: P = A[6:0].
  - 8 KB: P[6] = A[0] and P[5:0] = A[6:1].
  - 16 KB: P[6:5] = A[1:0] and P[4:0] = A[6:2].
  - 32 KB: P[6] = A[1], P[5] = A[2], P[4] = A[0] and P[3:0] = A[6:3].
- R6: On a hit that is allowed, the physical address is P shifted left by 12+s, with the low 12+s bits of the logical address passed through unchanged. The logical page number is `acc_addr_i` shifted right by 12+s.
- R7: An access that matches no valid slot raises `abort_o`, keeps `phys_valid_o` low and drives `phys_addr_o` to zero.
- R8: In supervisor mode (`acc_mode_i` = 00), reads and writes are allowed at every protection level.
- R9: In OS mode (`acc_mode_i` = 01), reads and writes are allowed at levels 0 and 1. At levels 2 and 3 only reads are allowed.
- R10: In user mode (`acc_mode_i` = 10 or 11), level 0 allows reads and writes, level 1 allows reads only, and levels 2 and 3 refuse every access.
- R11: While OS elevation is set, user-mode accesses are checked with the OS-mode rules.
- R12: A slot store for physical page P replaces P's earlier mapping and takes effect from the next cycle on.
- R13: If several valid slots hold the same logical page number, the lowest physical page number wins.
- R14: While `acc_valid_i` is low, `abort_o` and `phys_valid_o` both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store strobe for a control or table store |
| wr_addr_i | input | 26 | Store address, which carries both the target and the value |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | Access direction: 1 = write, 0 = read |
| acc_mode_i | input | 2 | Processor mode: 00 supervisor, 01 OS, 1x user |
| acc_addr_i | input | 25 | Logical address of the access |
| phys_valid_o | output | 1 | The access is translated and allowed |
| phys_addr_o | output | 22 | Physical address; zero unless `phys_valid_o` is high |
| abort_o | output | 1 | The access missed or was refused |

## Verification
The bound checker watches several behaviours on every cycle:
- idle accesses stay quiet;
- a miss always aborts and yields no address;
- supervisor hits are never refused;
- user writes to protected pages are always refused;
- in-page offset bits pass through unchanged;
- a slot store marks its slot valid one cycle later.

Other behaviours can only be shown by the bench's scenarios, because each needs a known store followed by a lookup:
- the bit unpacking for each page size;
- the position of the logical page field;
- replacement of an old mapping;
- lowest-page priority;
- OS elevation;
- stores outside both regions being ignored.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_8K  = 2'd1,
    PG_16K = 2'd2,
    PG_32K = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    MD_SVC = 2'd0,
    MD_OS  = 2'd1,
    MD_USR = 2'd2
  } mode_e;

  localparam int unsigned BASE_SHIFT = 12;
  localparam logic [2:0] TBL_SEL = 3'b111;      // addr[25:23]
  localparam logic [8:0] CTL_SEL = 9'h1B7;      // addr[25:17]

  // Unpack a physical page number from the low 7 store-address bits.
  function automatic logic [6:0] unpack_ppn(pg_size_e sz, logic [6:0] a);
    logic [6:0] p;
    unique case (sz)
      PG_4K:  p = a;
      PG_8K:  p = {a[0], a[6:1]};
      PG_16K: p = {a[1:0], a[6:2]};
      default: p = {a[1], a[2], a[0], a[6:3]};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pxu_wr_decode.sv
module pxu_wr_decode
  import pxu_pkg::*;
#(
  parameter int unsigned WADDR_W = 26,
  parameter int unsigned PPN_W   = 7,
  parameter int unsigned LPN_W   = 13
) (
  input  logic               wr_valid_i,
  input  logic [WADDR_W-1:0] wr_addr_i,
  input  pg_size_e           pg_size_i,
  output logic               ent_we_o,
  output logic [PPN_W-1:0]   ent_ppn_o,
  output logic [LPN_W-1:0]   ent_lpn_o,
  output logic [1:0]         ent_ppl_o,
  output logic               ctl_we_o,
  output pg_size_e           ctl_pg_size_o,
  output logic               ctl_os_o
);
  logic unused_addr_bit;
  assign unused_addr_bit = wr_addr_i[7];   // second-unit select, not modelled

  assign ent_we_o = wr_valid_i && (wr_addr_i[25:23] == TBL_SEL);
  assign ctl_we_o = wr_valid_i && (wr_addr_i[25:17] == CTL_SEL);

  assign ent_ppn_o = PPN_W'(unpack_ppn(pg_size_i, wr_addr_i[6:0]));
  assign ent_ppl_o = wr_addr_i[9:8];

  always_comb begin
    unique case (pg_size_i)
      PG_4K:   ent_lpn_o = LPN_W'({wr_addr_i[11:10], wr_addr_i[22:12]});
      PG_8K:   ent_lpn_o = LPN_W'({wr_addr_i[11:10], wr_addr_i[22:13]});
      PG_16K:  ent_lpn_o = LPN_W'({wr_addr_i[11:10], wr_addr_i[22:14]});
      default: ent_lpn_o = LPN_W'({wr_addr_i[11:10], wr_addr_i[22:15]});
    endcase
  end

  assign ctl_pg_size_o = pg_size_e'(wr_addr_i[3:2]);
  assign ctl_os_o      = wr_addr_i[12];
endmodule

// File: rtl/pxu_entry_table.sv
module pxu_entry_table #(
  parameter int unsigned NUM_PAGES = 128,
  parameter int unsigned LPN_W     = 13,
  localparam int unsigned PPN_W    = $clog2(NUM_PAGES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [PPN_W-1:0]     we_ppn_i,
  input  logic [LPN_W-1:0]     we_lpn_i,
  input  logic [1:0]           we_ppl_i,
  input  logic [LPN_W-1:0]     look_lpn_i,
  output logic                 hit_o,
  output logic [PPN_W-1:0]     hit_ppn_o,
  output logic [1:0]           hit_ppl_o,
  output logic [NUM_PAGES-1:0] vld_o
);
  logic [NUM_PAGES-1:0] vld_q;
  logic [LPN_W-1:0]     lpn_q [NUM_PAGES];
  logic [1:0]           ppl_q [NUM_PAGES];
  logic [NUM_PAGES-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[we_ppn_i] <= 1'b1;
  end

  // Slot contents carry no reset; the valid bits gate them.
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      lpn_q[we_ppn_i] <= we_lpn_i;
      ppl_q[we_ppn_i] <= we_ppl_i;
    end
  end

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (lpn_q[g] == look_lpn_i);
  end

  // Lowest-numbered page wins.
  always_comb begin
    hit_ppn_o = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (match[i]) hit_ppn_o = PPN_W'(i);
    end
  end

  assign hit_o     = |match;
  assign hit_ppl_o = ppl_q[hit_ppn_o];
  assign vld_o     = vld_q;
endmodule

// File: rtl/pxu_prot.sv
module pxu_prot
  import pxu_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       os_elev_i,
  input  logic       write_i,
  input  logic [1:0] ppl_i,
  output logic       allow_o
);
  mode_e eff_mode;

  always_comb begin
    if (mode_i[1]) eff_mode = os_elev_i ? MD_OS : MD_USR;
    else           eff_mode = mode_e'(mode_i);
  end

  always_comb begin
    unique case (eff_mode)
      MD_SVC:  allow_o = 1'b1;
      MD_OS:   allow_o = !write_i || !ppl_i[1];
      default: allow_o = (ppl_i == 2'd0) || ((ppl_i == 2'd1) && !write_i);
    endcase
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 128,
  parameter int unsigned LADDR_W   = 25,
  parameter int unsigned PADDR_W   = 22,
  parameter int unsigned WADDR_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [WADDR_W-1:0] wr_addr_i,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic [1:0]         acc_mode_i,
  input  logic [LADDR_W-1:0] acc_addr_i,
  output logic               phys_valid_o,
  output logic [PADDR_W-1:0] phys_addr_o,
  output logic               abort_o
);
  localparam int unsigned PPN_W = $clog2(NUM_PAGES);
  localparam int unsigned LPN_W = LADDR_W - BASE_SHIFT;

  pg_size_e             pg_size_q;
  logic                 os_q;
  logic                 tbl_we, ctl_we, ctl_os;
  pg_size_e             ctl_pg_size;
  logic [PPN_W-1:0]     tbl_we_ppn, tbl_hit_ppn;
  logic [LPN_W-1:0]     tbl_we_lpn, look_lpn;
  logic [1:0]           tbl_we_ppl, tbl_hit_ppl;
  logic                 tbl_hit, allow;
  logic [NUM_PAGES-1:0] vld_q;
  logic [4:0]           shamt;
  logic [PADDR_W-1:0]   off_mask, pa;

  pxu_wr_decode #(
    .WADDR_W(WADDR_W), .PPN_W(PPN_W), .LPN_W(LPN_W)
  ) u_dec (
    .wr_valid_i    (wr_valid_i),
    .wr_addr_i     (wr_addr_i),
    .pg_size_i     (pg_size_q),
    .ent_we_o      (tbl_we),
    .ent_ppn_o     (tbl_we_ppn),
    .ent_lpn_o     (tbl_we_lpn),
    .ent_ppl_o     (tbl_we_ppl),
    .ctl_we_o      (ctl_we),
    .ctl_pg_size_o (ctl_pg_size),
    .ctl_os_o      (ctl_os)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_size_q <= PG_4K;
      os_q      <= 1'b0;
    end else if (ctl_we) begin
      pg_size_q <= ctl_pg_size;
      os_q      <= ctl_os;
    end
  end

  assign shamt    = 5'(BASE_SHIFT) + {3'b000, pg_size_q};
  assign look_lpn = LPN_W'(acc_addr_i >> shamt);

  pxu_entry_table #(
    .NUM_PAGES(NUM_PAGES), .LPN_W(LPN_W)
  ) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we),
    .we_ppn_i   (tbl_we_ppn),
    .we_lpn_i   (tbl_we_lpn),
    .we_ppl_i   (tbl_we_ppl),
    .look_lpn_i (look_lpn),
    .hit_o      (tbl_hit),
    .hit_ppn_o  (tbl_hit_ppn),
    .hit_ppl_o  (tbl_hit_ppl),
    .vld_o      (vld_q)
  );

  pxu_prot u_prot (
    .mode_i    (acc_mode_i),
    .os_elev_i (os_q),
    .write_i   (acc_write_i),
    .ppl_i     (tbl_hit_ppl),
    .allow_o   (allow)
  );

  assign off_mask = ~({PADDR_W{1'b1}} << shamt);
  assign pa = (PADDR_W'(tbl_hit_ppn) << shamt) | (PADDR_W'(acc_addr_i) & off_mask);

  assign phys_valid_o = acc_valid_i && tbl_hit && allow;
  assign abort_o      = acc_valid_i && !(tbl_hit && allow);
  assign phys_addr_o  = phys_valid_o ? pa : '0;
endmodule

// File: rtl/page_xlate_unit_chk.sv
module page_xlate_unit_chk #(
  parameter int unsigned NUM_PAGES = 128,
  parameter int unsigned LADDR_W   = 25,
  parameter int unsigned PADDR_W   = 22,
  localparam int unsigned PPN_W    = $clog2(NUM_PAGES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 acc_valid_i,
  input logic                 acc_write_i,
  input logic [1:0]           acc_mode_i,
  input logic [LADDR_W-1:0]   acc_addr_i,
  input logic                 phys_valid_o,
  input logic [PADDR_W-1:0]   phys_addr_o,
  input logic                 abort_o,
  input logic                 hit_i,
  input logic [1:0]           hit_ppl_i,
  input logic                 os_i,
  input logic                 tbl_we_i,
  input logic [PPN_W-1:0]     tbl_we_ppn_i,
  input logic [NUM_PAGES-1:0] vld_i
);
  // R14
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!abort_o && !phys_valid_o));

  // R7
  miss_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !hit_i) |-> (abort_o && !phys_valid_o && phys_addr_o == '0));

  // R8
  svc_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hit_i && acc_mode_i == 2'b00) |-> phys_valid_o);

  // R10
  user_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hit_i && acc_mode_i[1] && !os_i && acc_write_i && hit_ppl_i != 2'd0)
      |-> abort_o);

  // R6
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_valid_o |-> (phys_addr_o[11:0] == acc_addr_i[11:0]));

  // R12
  entry_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |=> vld_i[$past(tbl_we_ppn_i)]);
endmodule

bind page_xlate_unit page_xlate_unit_chk #(
  .NUM_PAGES(NUM_PAGES), .LADDR_W(LADDR_W), .PADDR_W(PADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .acc_mode_i   (acc_mode_i),
  .acc_addr_i   (acc_addr_i),
  .phys_valid_o (phys_valid_o),
  .phys_addr_o  (phys_addr_o),
  .abort_o      (abort_o),
  .hit_i        (tbl_hit),
  .hit_ppl_i    (tbl_hit_ppl),
  .os_i         (os_q),
  .tbl_we_i     (tbl_we),
  .tbl_we_ppn_i (tbl_we_ppn),
  .vld_i        (vld_q)
);

// File: tb/page_xlate_unit_bench.sv
module page_xlate_unit_bench;
  localparam int unsigned NV = 12;
  localparam longint TIMEOUT = 64'd200000 * 64'd20;

  // {mode[1:0], write, laddr[24:0], abort, paddr[21:0]}
  localparam logic [50:0] VECS [NV] = '{
    {2'd0, 1'b0, 25'h1529234, 1'b0, 22'h299234},  // svc rd lvl1
    {2'd2, 1'b0, 25'h1529234, 1'b0, 22'h299234},  // usr rd lvl1
    {2'd2, 1'b1, 25'h1529234, 1'b1, 22'h000000},  // usr wr lvl1
    {2'd1, 1'b1, 25'h1529234, 1'b0, 22'h299234},  // os wr lvl1
    {2'd1, 1'b1, 25'h0088040, 1'b1, 22'h000000},  // os wr lvl2
    {2'd1, 1'b0, 25'h0088040, 1'b0, 22'h070040},  // os rd lvl2
    {2'd2, 1'b0, 25'h0088040, 1'b1, 22'h000000},  // usr rd lvl2
    {2'd0, 1'b1, 25'h1FFFFFF, 1'b0, 22'h387FFF},  // svc wr lvl3
    {2'd3, 1'b1, 25'h0000000, 1'b0, 22'h008000},  // usr wr lvl0
    {2'd0, 1'b0, 25'h0AA8010, 1'b1, 22'h000000},  // miss
    {2'd2, 1'b0, 25'h1FFFFFF, 1'b1, 22'h000000},  // usr rd lvl3
    {2'd1, 1'b0, 25'h1FFFFFF, 1'b0, 22'h387FFF}   // os rd lvl3
  };
  string vreq [NV] = '{"R8", "R10", "R10", "R9", "R9", "R9",
                       "R10", "R8", "R10", "R7", "R10", "R9"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [25:0] wr_addr_i = '0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [1:0]  acc_mode_i = '0;
  logic [24:0] acc_addr_i = '0;
  logic        phys_valid_o, abort_o;
  logic [21:0] phys_addr_o;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  page_xlate_unit u_page_xlate_unit (
    .clk_i, .rst_ni, .wr_valid_i, .wr_addr_i, .acc_valid_i, .acc_write_i,
    .acc_mode_i, .acc_addr_i, .phys_valid_o, .phys_addr_o, .abort_o
  );

  function automatic logic [25:0] enc_ent(int s, logic [6:0] p, logic [12:0] l, logic [1:0] lv);
    logic [25:0] a;
    a = 26'h3800000;
    a[9:8] = lv;
    case (s)
      0: begin a[6:0] = p; a[11:10] = l[12:11]; a[22:12] = l[10:0]; end
      1: begin a[0] = p[6]; a[6:1] = p[5:0]; a[11:10] = l[11:10]; a[22:13] = l[9:0]; end
      2: begin a[1:0] = p[6:5]; a[6:2] = p[4:0]; a[11:10] = l[10:9]; a[22:14] = l[8:0]; end
      default: begin
        a[1] = p[6]; a[2] = p[5]; a[0] = p[4]; a[6:3] = p[3:0];
        a[11:10] = l[9:8]; a[22:15] = l[7:0];
      end
    endcase
    return a;
  endfunction

  function automatic logic [25:0] enc_ctl(int s, logic os);
    return 26'h36E0000 | 26'(s << 2) | (os ? 26'h0001000 : 26'h0);
  endfunction

  task automatic store(input logic [25:0] a);
    @(negedge clk_i);
    wr_valid_i = 1'b1;
    wr_addr_i  = a;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    wr_addr_i  = '0;
  endtask

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got abort=%0b pa=%h, expected abort=%0b pa=%h",
               req, act[22], act[21:0], exp[22], exp[21:0]);
    end
  endtask

  // Drives one access and checks {abort, paddr}; valid must equal !abort.
  task automatic access(input string req, input logic [1:0] md, input logic wr,
                        input logic [24:0] la, input logic ab, input logic [21:0] pa);
    @(negedge clk_i);
    acc_valid_i = 1'b1;
    acc_mode_i  = md;
    acc_write_i = wr;
    acc_addr_i  = la;
    #2;
    chk(req, {abort_o, phys_addr_o}, {ab, pa});
    chk(req, {1'b0, 21'd0, phys_valid_o}, {1'b0, 21'd0, !ab});
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  initial begin
    #(TIMEOUT);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty table after reset
    access("R1", 2'd0, 1'b0, 25'h0000000, 1'b1, 22'h0);
    access("R1", 2'd0, 1'b0, 25'h1803123, 1'b1, 22'h0);

    // R14: idle request
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    acc_addr_i  = 25'h1803123;
    #2;
    chk("R14", {abort_o, 21'd0, phys_valid_o}, 23'd0);

    // R4 R5 R6: 4 KB, LPN uses A[11:10]
    store(enc_ent(0, 7'h05, 13'h1803, 2'd0));
    access("R4", 2'd0, 1'b0, 25'h1803123, 1'b0, 22'h005123);

    // R3 R5: 8 KB
    store(enc_ctl(1, 1'b0));
    store(enc_ent(1, 7'h41, 13'h0FFF, 2'd0));
    access("R5", 2'd0, 1'b1, 25'h1FFFABC, 1'b0, 22'h083ABC);

    // R3 R5: 16 KB
    store(enc_ctl(2, 1'b0));
    store(enc_ent(2, 7'h65, 13'h05A3, 2'd0));
    access("R5", 2'd0, 1'b0, 25'h168E345, 1'b0, 22'h196345);

    // R3 R5: 32 KB table for the vector walk
    store(enc_ctl(3, 1'b0));
    store(enc_ent(3, 7'h53, 13'h02A5, 2'd1));
    store(enc_ent(3, 7'h0E, 13'h0011, 2'd2));
    store(enc_ent(3, 7'h70, 13'h03FF, 2'd3));
    store(enc_ent(3, 7'h01, 13'h0000, 2'd0));

    for (int i = 0; i < NV; i++) begin
      access(vreq[i], VECS[i][50:49], VECS[i][48], VECS[i][47:23],
             VECS[i][22], VECS[i][21:0]);
    end

    // R12: remap page 0x53
    store(enc_ent(3, 7'h53, 13'h0100, 2'd1));
    access("R12", 2'd0, 1'b0, 25'h1529234, 1'b1, 22'h0);
    access("R12", 2'd0, 1'b0, 25'h0801234, 1'b0, 22'h299234);

    // R2: store outside both regions is ignored
    store(26'h02A8400 | 26'h0000005);
    access("R2", 2'd0, 1'b0, 25'h0AA8010, 1'b1, 22'h0);
    store(26'h36C000C);
    access("R2", 2'd0, 1'b0, 25'h1FFFFFF, 1'b0, 22'h387FFF);

    // R13: duplicate LPN, lowest page wins
    store(enc_ent(3, 7'h02, 13'h03FF, 2'd0));
    access("R13", 2'd0, 1'b0, 25'h1FFFFFF, 1'b0, 22'h017FFF);

    // R11: OS elevation for user mode
    store(enc_ctl(3, 1'b1));
    access("R11", 2'd2, 1'b1, 25'h0801234, 1'b0, 22'h299234);
    access("R11", 2'd2, 1'b0, 25'h0088040, 1'b0, 22'h070040);
    access("R11", 2'd2, 1'b1, 25'h0088040, 1'b1, 22'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule